// File: doc/BRIEF.md
# Strip Hit Cluster Finder

The block examines a 64-bit vector of strip hits once per clock and locates every run of neighbouring set bits (a cluster). The strips are grouped into sixteen four-strip blocks. Each block inspects its own four bits together with one strip of context below and two strips above. From these it gives up to two cluster starts, each with a width code. A run that reaches over a block edge is counted once only, in the block that holds its lowest strip. That block's index becomes the cluster's coarse address.

A programmable width limit removes wide clusters. A priority stage then packs the survivors, lowest address first, into six output slots. Each slot carries a valid flag, a 4-bit block address and a 2-bit width code. The outputs are registered. They are refreshed only on a cycle that has at least one hit, so an idle input leaves them unchanged.

Top module: `strip_cluster_finder`

## Requirements
- R1: While `rst` is high, the clock edge clears every slot valid flag, address field and width field to zero.
- R2: Each maximal run of set bits in `hit_i` is reported exactly once. Its address is the index of its lowest strip divided by 4 (integer division).
- R3: The width code is the run length when that length is 1, 2 or 3. It is 3 for any longer run.
- R4: A run that spans one or more block edges appears as a single cluster, at the address of the block holding its lowest strip.
- R5: A cluster is kept only when its width code, extended to 3 bits, is strictly less than `wthr_i`. A value of 0 drops all clusters, and a value of 4 or more keeps all of them.
- R6: When more than six clusters survive, the six with the lowest strip positions are reported. Slot 0 holds the lowest, and the slots rise in order of strip position.
- R7: Slots are filled from slot 0 upward. Every slot beyond the number of surviving clusters has its valid flag at 0.
- R8: A result appears at the outputs on the first clock edge after the hit vector is applied. It is not visible before that edge.
- R9: A clock edge with `hit_i` all zero leaves every output unchanged, whatever the value of `wthr_i`.
- R10: A single four-strip block can give two separate clusters. An example is strips 0 and 2 of one block, with strips 1 and 3 clear. Both clusters are reported with the same address, and the lower strip goes in the lower slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | 64 | Strip hit bits, bit n is strip n |
| wthr_i | input | 3 | Width limit; keep when width code < value |
| cl_valid_o | output | 6 | Slot valid flags, bit k is slot k |
| cl_addr_o | output | 24 | Slot k block address at bits [4k+3:4k] |
| cl_width_o | output | 12 | Slot k width code at bits [2k+1:2k] |

## Verification
The hardest cases to reach from the ports are runs that cross one or two block edges while a second run sits close by. A merge error shows up only when the context bits of two neighbouring blocks interact. The stimulus therefore sweeps every 12-bit pattern across strips 2 to 13, which covers three block edges. It also walks runs of every length from 1 to 8 across every start position. Overflow of the six slots is driven by alternating-strip and dense pseudo-random vectors.

// File: rtl/scf_pkg.sv
package scf_pkg;
  localparam int WID_W = 2;

  // Saturating run-length code from the strip itself and the two above it.
  function automatic logic [WID_W-1:0] run_code(input logic s0, input logic s1, input logic s2);
    run_code = {1'b0, s0} + {1'b0, s0 & s1} + {1'b0, s0 & s1 & s2};
  endfunction
endpackage

// File: rtl/scf_blk.sv
module scf_blk
  import scf_pkg::*;
#(
  parameter int BLK_W = 4,
  parameter int MAXC  = (BLK_W + 1) / 2
) (
  // ext_i[0] = strip below block, [BLK_W:1] = block strips, top two = strips above
  input  logic [BLK_W+2:0]       ext_i,
  output logic [MAXC-1:0]        cand_v_o,
  output logic [MAXC*WID_W-1:0]  cand_w_o
);
  localparam int LUT_N = 2 ** BLK_W;

  // Start-mask lookup on the block's own bits, assuming a clear strip below.
  function automatic logic [BLK_W-1:0] start_lut(input logic [BLK_W-1:0] q);
    logic [BLK_W-1:0] m;
    m[0] = q[0];
    for (int j = 1; j < BLK_W; j++) m[j] = q[j] & ~q[j-1];
    return m;
  endfunction

  logic [BLK_W-1:0] lut [LUT_N];
  always_comb begin
    for (int e = 0; e < LUT_N; e++) lut[e] = start_lut(BLK_W'(e));
  end

  logic [BLK_W-1:0] quad;
  logic [BLK_W-1:0] starts;
  logic [WID_W-1:0] rc [BLK_W];

  assign quad = ext_i[BLK_W:1];

  // Merge with the lower neighbour: a run continuing from below is not a start here.
  always_comb begin
    starts    = lut[quad];
    starts[0] = starts[0] & ~ext_i[0];
  end

  // Run length looks into the blocks above, so edge-crossing runs keep their width.
  generate
    for (genvar j = 0; j < BLK_W; j++) begin : g_rc
      assign rc[j] = run_code(ext_i[j+1], ext_i[j+2], ext_i[j+3]);
    end
  endgenerate

  always_comb begin
    int n;
    n        = 0;
    cand_v_o = '0;
    cand_w_o = '0;
    for (int j = 0; j < BLK_W; j++) begin
      if (starts[j] && n < MAXC) begin
        cand_v_o[n]                 = 1'b1;
        cand_w_o[n*WID_W +: WID_W]  = rc[j];
        n                           = n + 1;
      end
    end
  end
endmodule

// File: rtl/scf_prienc.sv
module scf_prienc
  import scf_pkg::*;
#(
  parameter int N_CAND = 32,
  parameter int N_SLOT = 6,
  parameter int ADDR_W = 4
) (
  input  logic [N_CAND-1:0]         cand_v_i,
  input  logic [N_CAND*ADDR_W-1:0]  cand_a_i,
  input  logic [N_CAND*WID_W-1:0]   cand_w_i,
  output logic [N_SLOT-1:0]         slot_v_o,
  output logic [N_SLOT*ADDR_W-1:0]  slot_a_o,
  output logic [N_SLOT*WID_W-1:0]   slot_w_o
);
  // Candidates arrive ordered by strip; the first N_SLOT valid ones win.
  always_comb begin
    int n;
    n        = 0;
    slot_v_o = '0;
    slot_a_o = '0;
    slot_w_o = '0;
    for (int c = 0; c < N_CAND; c++) begin
      if (cand_v_i[c] && n < N_SLOT) begin
        slot_v_o[n]                   = 1'b1;
        slot_a_o[n*ADDR_W +: ADDR_W]  = cand_a_i[c*ADDR_W +: ADDR_W];
        slot_w_o[n*WID_W +: WID_W]    = cand_w_i[c*WID_W +: WID_W];
        n                             = n + 1;
      end
    end
  end
endmodule

// File: rtl/strip_cluster_finder.sv
module strip_cluster_finder
  import scf_pkg::*;
#(
  parameter int N_STRIPS = 64,
  parameter int BLK_W    = 4,
  parameter int N_SLOTS  = 6,
  parameter int THR_W    = 3,
  localparam int N_BLK   = N_STRIPS / BLK_W,
  localparam int ADDR_W  = $clog2(N_BLK),
  localparam int MAXC    = (BLK_W + 1) / 2,
  localparam int N_CAND  = N_BLK * MAXC
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_STRIPS-1:0]         hit_i,
  input  logic [THR_W-1:0]            wthr_i,
  output logic [N_SLOTS-1:0]          cl_valid_o,
  output logic [N_SLOTS*ADDR_W-1:0]   cl_addr_o,
  output logic [N_SLOTS*WID_W-1:0]    cl_width_o
);
  logic [N_STRIPS+2:0]        hpad;
  logic [N_CAND-1:0]          raw_v;
  logic [N_CAND-1:0]          cut_v;
  logic [N_CAND*ADDR_W-1:0]   cand_a;
  logic [N_CAND*WID_W-1:0]    cand_w;
  logic [N_SLOTS-1:0]         nxt_v;
  logic [N_SLOTS*ADDR_W-1:0]  nxt_a;
  logic [N_SLOTS*WID_W-1:0]   nxt_w;
  logic                       awake;

  assign hpad  = {2'b00, hit_i, 1'b0};
  assign awake = |hit_i;

  generate
    for (genvar b = 0; b < N_BLK; b++) begin : g_blk
      scf_blk #(.BLK_W(BLK_W), .MAXC(MAXC)) u_blk (
        .ext_i    (hpad[b*BLK_W +: BLK_W+3]),
        .cand_v_o (raw_v[b*MAXC +: MAXC]),
        .cand_w_o (cand_w[b*MAXC*WID_W +: MAXC*WID_W])
      );
      for (genvar k = 0; k < MAXC; k++) begin : g_cut
        assign cand_a[(b*MAXC+k)*ADDR_W +: ADDR_W] = ADDR_W'(b);
        assign cut_v[b*MAXC+k] = raw_v[b*MAXC+k] &&
          (THR_W'(cand_w[(b*MAXC+k)*WID_W +: WID_W]) < wthr_i);
      end
    end
  endgenerate

  scf_prienc #(.N_CAND(N_CAND), .N_SLOT(N_SLOTS), .ADDR_W(ADDR_W)) u_pe (
    .cand_v_i (cut_v),
    .cand_a_i (cand_a),
    .cand_w_i (cand_w),
    .slot_v_o (nxt_v),
    .slot_a_o (nxt_a),
    .slot_w_o (nxt_w)
  );

  // Wake-up gated output registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      cl_valid_o <= '0;
      cl_addr_o  <= '0;
      cl_width_o <= '0;
    end else if (awake) begin
      cl_valid_o <= nxt_v;
      cl_addr_o  <= nxt_a;
      cl_width_o <= nxt_w;
    end
  end

  // R1: reset clears outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (cl_valid_o == '0 && cl_addr_o == '0 && cl_width_o == '0));

  // R7: valid slots packed from slot 0
  a_r7_packed: assert property (@(posedge clk) disable iff (rst)
    ((cl_valid_o & (cl_valid_o + 1'b1)) == '0));

  // R9: idle input holds outputs
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(hit_i) == '0 && !$past(rst)) |->
      ($stable(cl_valid_o) && $stable(cl_addr_o) && $stable(cl_width_o)));

  generate
    for (genvar k = 0; k < N_SLOTS; k++) begin : g_sa
      // R5: every reported cluster passed the width cut in force when captured
      a_r5_width_cut: assert property (@(posedge clk) disable iff (rst)
        ($past(|hit_i) && cl_valid_o[k]) |->
          (THR_W'(cl_width_o[k*WID_W +: WID_W]) < $past(wthr_i)));
    end
    for (genvar k = 0; k + 1 < N_SLOTS; k++) begin : g_ord
      // R6: addresses non-decreasing across valid slots
      a_r6_order: assert property (@(posedge clk) disable iff (rst)
        cl_valid_o[k+1] |->
          (cl_addr_o[k*ADDR_W +: ADDR_W] <= cl_addr_o[(k+1)*ADDR_W +: ADDR_W]));
    end
  endgenerate
endmodule

// File: tb/tb_strip_cluster_finder.sv
`timescale 1ns/1ps
module tb_strip_cluster_finder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] hit = '0;
  logic [2:0]  thr = 3'd4;
  logic [5:0]  cl_valid;
  logic [23:0] cl_addr;
  logic [11:0] cl_width;

  logic [5:0]  exp_v = '0;
  logic [23:0] exp_a = '0;
  logic [11:0] exp_w = '0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  strip_cluster_finder dut (
    .clk(clk), .rst(rst), .hit_i(hit), .wthr_i(thr),
    .cl_valid_o(cl_valid), .cl_addr_o(cl_addr), .cl_width_o(cl_width)
  );

  // Reference: scan runs, filter by width code, keep first six.
  task automatic model(input logic [63:0] h, input logic [2:0] t);
    int n, i, st, len, code;
    exp_v = '0; exp_a = '0; exp_w = '0;
    n = 0; i = 0;
    while (i < 64) begin
      if (h[i]) begin
        st = i; len = 0;
        while (i < 64 && h[i]) begin len++; i++; end
        code = (len > 3) ? 3 : len;
        if (code < int'(t) && n < 6) begin
          exp_v[n] = 1'b1;
          exp_a[n*4 +: 4] = 4'(st / 4);
          exp_w[n*2 +: 2] = 2'(code);
          n++;
        end
      end else i++;
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (cl_valid !== exp_v || cl_addr !== exp_a || cl_width !== exp_w) begin
      errors++;
      $display("FAIL %s hit=%h thr=%0d got v=%b a=%h w=%h exp v=%b a=%h w=%h",
               tag, hit, thr, cl_valid, cl_addr, cl_width, exp_v, exp_a, exp_w);
    end
  endtask

  // Called at a negedge; applies stimulus and checks one cycle later.
  task automatic step(input logic [63:0] h, input logic [2:0] t, input string tag);
    hit = h; thr = t;
    if (h != '0) model(h, t);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] x;
    // R1: reset state, with hits present during reset
    hit = 64'hF0F0_0000_0000_1234;
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst = 1'b0;
    hit = '0;
    @(negedge clk);
    compare("R1 after release idle");

    // R2 / R4 / R10: every pattern over strips 2..13 (three block edges)
    for (int p = 1; p < 4096; p++) step(64'(p) << 2, 3'd4, "R2 R4 R10 sweep");

    // R3 / R4: runs of length 1..8 at every start
    for (int len = 1; len <= 8; len++)
      for (int s = 0; s + len <= 64; s++)
        step(((64'd1 << len) - 64'd1) << s, 3'd4, "R3 R4 run walk");

    // R5: every 8-bit pattern on strips 6..13 under every limit
    for (int t = 0; t < 8; t++)
      for (int p = 1; p < 256; p++) step(64'(p) << 6, 3'(t), "R5 cut sweep");

    // R10: alternating strips, two clusters per block; R6 overflow
    step(64'h5555_5555_5555_5555, 3'd4, "R10 R6 alternating");
    step(64'hAAAA_AAAA_AAAA_AAAA, 3'd2, "R10 R6 alternating odd");

    // R6: dense pseudo-random vectors
    x = 64'h9E37_79B9_7F4A_7C15;
    for (int r = 0; r < 600; r++) begin
      x ^= x << 13; x ^= x >> 7; x ^= x << 17;
      step((r % 2 == 0) ? x : (x & (x >> 3)), 3'(2 + r % 3), "R6 dense");
    end

    // R7: fewer survivors than slots, then none at all
    step(64'h0000_0000_0000_0101, 3'd4, "R7 two clusters");
    step(64'hFF00_0000_0000_0000, 3'd3, "R7 all cut");

    // R9: idle input holds a prior result while the limit changes
    step(64'h0000_0003_0000_0011, 3'd4, "R9 load");
    step(64'h0, 3'd0, "R9 idle hold");
    step(64'h0, 3'd7, "R9 idle hold again");

    // R8: result not visible before the capturing edge
    step(64'h0000_0000_0000_0007, 3'd4, "R8 first");
    hit = 64'h0000_0000_0010_0000; thr = 3'd4;
    #2.0;
    compare("R8 before edge");
    model(hit, thr);
    @(negedge clk);
    compare("R8 after edge");

    finish_run();
  end
endmodule